// File: doc/BRIEF.md
# Interrupt Status and Acknowledge Unit

This block holds the interrupt status byte of a network controller's host control block and drives a single level-sensitive interrupt line toward the host. Internal units of the controller report events as one-cycle pulses. Each pulse latches a status bit that stays set until software clears it. The events are: command complete, command unit idle, frame received, receiver not ready, management cycle done, software request and flow-control pause.

The host reaches the block through a small register port with two byte registers. The acknowledge byte reads back the latched status, and writing it clears every bit written as 1. The mask byte holds a per-source mask in its upper four bits and a global disable in bit 0. Bit 1 of the mask byte is a self-clearing trigger that raises the software-request status bit. The interrupt line is recomputed whenever an event is latched. An acknowledge can only drop the line, and only once no status bit is left at all.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is active, the status byte and the mask byte read 0x00 and `irq_o` is low.
- R2: An `evt_i` pulse on bit k sets status bit k at the next clock edge. The bit meanings are: bit 7 command complete, bit 6 frame received, bit 5 command unit idle, bit 4 receiver not ready, bit 3 management cycle done, bit 2 software request, bit 0 flow-control pause. Bit 1 is reserved: a pulse on it has no effect, and status bit 1 always reads 0.
- R3: In a cycle that latches at least one event, the next `irq_o` is 1 exactly when (new status AND (NOT new mask OR 0x0F)) is nonzero and new mask bit 0 is 0.
- R4: Status bits 3, 2 and 0 raise the line whatever the values of mask bits 7..4.
- R5: With mask bit 0 set, an event cycle leaves `irq_o` low.
- R6: A write with `reg_sel_i`=0 clears every status bit written as 1 and leaves the others unchanged.
- R7: After an acknowledge with no event, `irq_o` goes low if the whole status byte is 0x00. Otherwise it keeps its value, even when every remaining bit is masked.
- R8: A write with `reg_sel_i`=1 stores the mask. If bit 1 of the written data is 1, status bit 2 is set and the cycle is evaluated as an event, using the new mask. Mask bit 1 is never stored and reads 0.
- R9: When an event and an acknowledge of the same bit fall in one cycle, the bit ends up set.
- R10: A mask write whose bit 1 is 0, in a cycle with no event, leaves `irq_o` unchanged.
- R11: `irq_o` and both registers change only on rising clock edges. Cycles with no write and no event change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one bit per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 acknowledge/status, 1 mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Level-sensitive interrupt line |

## Verification
The bench builds the block with its default parameters: an 8-bit status byte, a 4-bit mask-bypass field, the global disable at bit 0, the trigger at bit 1 and the software bit at 2. At this size random stimulus covers every mask value and every status combination. Directed steps set up the cases that matter: an acknowledge that leaves only masked bits while the line stays high, an event cleared and set in the same cycle, and the self-clearing trigger with and without the global disable.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        SEL_ACK  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge #(
    parameter int unsigned        STATUS_W  = 8,
    parameter logic [STATUS_W-1:0] RSVD_MASK = 8'h02,
    parameter int unsigned        SWI_BIT   = 2,
    parameter int unsigned        DRV_BIT   = 1
) (
    input  logic [STATUS_W-1:0] evt_i,
    input  logic                mask_wr_i,
    input  logic [STATUS_W-1:0] wdata_i,
    output logic [STATUS_W-1:0] set_o
);
    logic drv_req;

    assign drv_req = mask_wr_i & wdata_i[DRV_BIT];

    for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
        if (RSVD_MASK[b]) begin : g_rsvd
            assign set_o[b] = 1'b0;
        end else if (b == SWI_BIT) begin : g_swi
            assign set_o[b] = evt_i[b] | drv_req;
        end else begin : g_plain
            assign set_o[b] = evt_i[b];
        end
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int unsigned STATUS_W = 8,
    parameter int unsigned BYPASS_W = 4,
    parameter int unsigned DIS_BIT  = 0
) (
    input  logic [STATUS_W-1:0] status_i,
    input  logic [STATUS_W-1:0] mask_i,
    output logic                req_o
);
    localparam logic [STATUS_W-1:0] BYPASS_MASK = STATUS_W'((1 << BYPASS_W) - 1);

    logic [STATUS_W-1:0] eff;

    assign eff   = status_i & (~mask_i | BYPASS_MASK);
    assign req_o = (|eff) & ~mask_i[DIS_BIT];
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned         STATUS_W  = irq_stat_pkg::BYTE_W,
    parameter int unsigned         BYPASS_W  = 4,
    parameter int unsigned         DIS_BIT   = 0,
    parameter int unsigned         DRV_BIT   = 1,
    parameter int unsigned         SWI_BIT   = 2,
    parameter logic [STATUS_W-1:0] RSVD_MASK = 8'h02
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] evt_i,
    input  logic                reg_wr_i,
    input  logic                reg_sel_i,
    input  logic [STATUS_W-1:0] reg_wdata_i,
    output logic [STATUS_W-1:0] reg_rdata_o,
    output logic                irq_o
);
    import irq_stat_pkg::*;

    localparam logic [STATUS_W-1:0] DRV_MASK = STATUS_W'(1 << DRV_BIT);

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic [STATUS_W-1:0] mask;
        logic                irq;
    } state_t;

    state_t state_d, state_q;

    logic                ack_wr;
    logic                mask_wr;
    logic [STATUS_W-1:0] set_vec;
    logic                gate_req;

    assign ack_wr  = reg_wr_i & (reg_sel_e'(reg_sel_i) == SEL_ACK);
    assign mask_wr = reg_wr_i & (reg_sel_e'(reg_sel_i) == SEL_MASK);

    irq_event_merge #(
        .STATUS_W (STATUS_W),
        .RSVD_MASK(RSVD_MASK),
        .SWI_BIT  (SWI_BIT),
        .DRV_BIT  (DRV_BIT)
    ) u_merge (
        .evt_i    (evt_i),
        .mask_wr_i(mask_wr),
        .wdata_i  (reg_wdata_i),
        .set_o    (set_vec)
    );

    irq_gate #(
        .STATUS_W(STATUS_W),
        .BYPASS_W(BYPASS_W),
        .DIS_BIT (DIS_BIT)
    ) u_gate (
        .status_i(state_d.status),
        .mask_i  (state_d.mask),
        .req_o   (gate_req)
    );

    always_comb begin
        state_d = state_q;
        if (mask_wr) begin
            state_d.mask = reg_wdata_i & ~DRV_MASK;
        end
        if (ack_wr) begin
            state_d.status = state_q.status & ~reg_wdata_i;
        end
        state_d.status = state_d.status | set_vec;
        if (|set_vec) begin
            state_d.irq = gate_req;
        end else if (ack_wr && (state_d.status == '0)) begin
            state_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_MASK) ? state_q.mask : state_q.status;
    assign irq_o       = state_q.irq;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int unsigned         STATUS_W  = 8,
    parameter logic [STATUS_W-1:0] RSVD_MASK = 8'h02,
    parameter int unsigned         DIS_BIT   = 0,
    parameter int unsigned         DRV_BIT   = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] evt_i,
    input logic                reg_wr_i,
    input logic                reg_sel_i,
    input logic [STATUS_W-1:0] reg_wdata_i,
    input logic                irq_o,
    input logic [STATUS_W-1:0] status_q,
    input logic [STATUS_W-1:0] mask_q
);
    logic [STATUS_W-1:0] live_evt;
    logic                no_evt;

    assign live_evt = evt_i & ~RSVD_MASK;
    assign no_evt   = (live_evt == '0);

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (status_q == '0 && mask_q == '0 && !irq_o);
        end
    end

    assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !no_evt |=> ((status_q & $past(live_evt)) == $past(live_evt)));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & RSVD_MASK) == '0);

    assert_global_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !no_evt |=> (mask_q[DIS_BIT] -> !irq_o));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && no_evt) |=> ((status_q & $past(reg_wdata_i)) == '0));

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && no_evt) |=> ((status_q == '0) ? !irq_o : $stable(irq_o)));

    assert_drv_bit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[DRV_BIT]);

    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && no_evt) |=> ($stable(irq_o) && $stable(status_q) && $stable(mask_q)));
endmodule

bind irq_status_unit irq_status_chk #(
    .STATUS_W (STATUS_W),
    .RSVD_MASK(RSVD_MASK),
    .DIS_BIT  (DIS_BIT),
    .DRV_BIT  (DRV_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .reg_wr_i   (reg_wr_i),
    .reg_sel_i  (reg_sel_i),
    .reg_wdata_i(reg_wdata_i),
    .irq_o      (irq_o),
    .status_q   (state_q.status),
    .mask_q     (state_q.mask)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       reg_wr_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_status = '0;
    logic [7:0] m_mask = '0;
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .reg_wr_i   (reg_wr_i),
        .reg_sel_i  (reg_sel_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .irq_o      (irq_o)
    );

    // Expected line value for an event cycle (R3, R4, R5).
    function automatic logic line_after_event(logic [7:0] st, logic [7:0] mk);
        return ((st & (~mk | 8'h0F)) != 8'h00) && !mk[0];
    endfunction

    // Requirement-level model of one clock edge.
    task automatic model_edge(logic [7:0] evt, logic wr, logic sel, logic [7:0] wd);
        logic [7:0] setv = evt & 8'hFD;
        logic [7:0] ack = 8'h00;
        if (wr && sel) begin
            m_mask = wd & 8'hFD;
            if (wd[1]) setv = setv | 8'h04;
        end
        if (wr && !sel) ack = wd;
        m_status = (m_status & ~ack) | setv;
        if (setv != 8'h00) m_irq = line_after_event(m_status, m_mask);
        else if (wr && !sel && m_status == 8'h00) m_irq = 1'b0;
    endtask

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        reg_sel_i = 1'b0;
        #1;
        cmp(tag, "status", reg_rdata_o, m_status);
        reg_sel_i = 1'b1;
        #1;
        cmp(tag, "mask", reg_rdata_o, m_mask);
        cmp(tag, "irq", {7'd0, irq_o}, {7'd0, m_irq});
    endtask

    task automatic step(string tag, logic [7:0] evt, logic wr, logic sel, logic [7:0] wd);
        @(negedge clk);
        evt_i = evt;
        reg_wr_i = wr;
        reg_sel_i = sel;
        reg_wdata_i = wd;
        @(posedge clk);
        #1;
        evt_i = '0;
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
        model_edge(evt, wr, sel, wd);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #2;
        check_all("R1 reset");
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 reset held");
        @(negedge clk);
        rst_n = 1'b1;

        step("R2 R3 command done raises line", 8'h80, 1'b0, 1'b0, 8'h00);
        step("R6 R7 ack clears all", 8'h00, 1'b1, 1'b0, 8'h80);
        step("R10 mask write", 8'h00, 1'b1, 1'b1, 8'h80);
        step("R3 masked source stays quiet", 8'h80, 1'b0, 1'b0, 8'h00);
        step("R10 mask write upper", 8'h00, 1'b1, 1'b1, 8'hF0);
        step("R4 low nibble bypasses mask", 8'h08, 1'b0, 1'b0, 8'h00);
        step("R6 R7 partial ack keeps line", 8'h00, 1'b1, 1'b0, 8'h08);
        step("R7 final ack drops line", 8'h00, 1'b1, 1'b0, 8'h80);
        step("R4 flow-control pause bypass", 8'h01, 1'b0, 1'b0, 8'h00);
        step("R7 ack pause", 8'h00, 1'b1, 1'b0, 8'h01);
        step("R10 set global disable", 8'h00, 1'b1, 1'b1, 8'h01);
        step("R5 global disable", 8'h04, 1'b0, 1'b0, 8'h00);
        step("R6 ack sw", 8'h00, 1'b1, 1'b0, 8'hFF);
        step("R8 drv trigger", 8'h00, 1'b1, 1'b1, 8'h02);
        step("R10 mask write keeps line", 8'h00, 1'b1, 1'b1, 8'h01);
        step("R9 ack and event together", 8'h04, 1'b1, 1'b0, 8'h04);
        step("R8 drv trigger with disable", 8'h00, 1'b1, 1'b1, 8'h03);
        step("R2 reserved bit ignored", 8'h02, 1'b0, 1'b0, 8'h00);
        step("R6 clear", 8'h00, 1'b1, 1'b0, 8'hFF);
        step("R11 idle cycle", 8'h00, 1'b0, 1'b0, 8'h00);
        for (int b = 0; b < 8; b++) begin
            step("R3 per-source mask set", 8'h00, 1'b1, 1'b1, 8'h80 >> b);
            step("R3 per-source event", 8'(1 << b), 1'b0, 1'b0, 8'h00);
            step("R7 per-source ack", 8'h00, 1'b1, 1'b0, 8'hFF);
        end

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ev;
            logic wr;
            ev = (($urandom % 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            wr = (($urandom % 2) == 0);
            step("R11 random", ev, wr, 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule